// File: doc/BRIEF.md
# Multi-Target Serial DAC Write Controller

This controller sits on the host side of a shared three-wire serial bus that feeds several 16-bit digital-to-analog converters. A client hands it one word and a target number through a valid/ready handshake. The controller decodes the target number into a single active-low select line and clocks the word out most significant bit first. Data changes while the serial clock is low and is captured by the target on the rising edge. If the client asks for it, the controller then pulses a shared active-low load strobe after the frame has closed.

Every interface interval comes from a nanosecond minimum and the system clock period. The controller turns each minimum into a whole number of system-clock cycles, rounding up. These intervals are: clock high and low time, select-to-clock setup, data setup, select hold after the last edge, select high time between frames, and the load strobe's delay and width. Outside a frame the serial clock and data lines are held low, so the shared wires carry no activity while they are idle.

Top module: `sdac_wr_ctrl`

## Requirements
- R1: After reset every select line is high, the serial clock and data are low, the load strobe is high and `req_ready` is high.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` stays low from that edge until the frame, any load pulse and the recovery time have all finished. A request held high while the controller is busy is taken exactly once.
- R3: During a frame exactly one select line is low, namely `dac_cs_n[i]` where i is the target number taken with the request. The other select lines stay high, and no two select lines are ever low at once.
- R4: Each frame carries exactly DATA_W (default 16) rising clock edges while the select line is low. Bit DATA_W-1 of the word is sent first and bit 0 last, so the addressed target receives the word unchanged.
- R5: The serial clock's high time and low time are each at least ceil(SCLK_HALF_NS / SYS_CLK_NS) cycles. Its period is therefore at least ceil(2*SCLK_HALF_NS / SYS_CLK_NS) cycles, with a 50% duty cycle.
- R6: The select line falls at least ceil(CS_SETUP_NS / SYS_CLK_NS) cycles before the first rising clock edge. Serial data changes only while the clock is low, and it is stable for at least ceil(DATA_SETUP_NS / SYS_CLK_NS) cycles before each rising edge.
- R7: The select line rises no sooner than ceil(CS_HOLD_NS / SYS_CLK_NS) cycles after the last rising clock edge of the frame.
- R8: Between two frames every select line stays high for at least ceil(CS_GAP_NS / SYS_CLK_NS) cycles.
- R9: While no select line is low, the serial clock and serial data are both low.
- R10: When `req_load` was high at acceptance, `dac_load_n` pulses low exactly once after the frame. The pulse starts at least ceil(LOAD_DELAY_NS / SYS_CLK_NS) cycles after the select line rises and lasts at least ceil(LOAD_WIDTH_NS / SYS_CLK_NS) cycles. The strobe is never low while a select line is low. When `req_load` was low, no pulse occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_data | input | DATA_W | Word to send |
| req_target | input | TGT_W | Target number, decoded to one select line |
| req_load | input | 1 | Pulse the load strobe after this frame |
| dac_sclk | output | 1 | Shared serial clock, idle low, gated between frames |
| dac_sdata | output | 1 | Shared serial data, MSB first |
| dac_cs_n | output | NUM_TGT | Per-target active-low select |
| dac_load_n | output | 1 | Shared active-low load strobe |

## Verification
Two events can land in the same cycle: a waiting request, and the tail of the previous transaction (the load pulse or the recovery count). The bench provokes this by raising `req_valid` again right after each acceptance and holding it through the busy period. It then checks that the request is taken only once recovery is over and that the select-high gap still meets R8. A second overlap is the serial clock falling on the final bit in the same cycle that the hold count starts. A cycle-level interval monitor judges this case by measuring the time from the last rising edge to the select release. Receiver models confirm that no extra bit is clocked into any target.

// File: rtl/sdac_wr_pkg.sv
package sdac_wr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_HIGH,
        ST_LOW,
        ST_HOLD,
        ST_LDGAP,
        ST_LDPULSE,
        ST_RECOV
    } sdw_state_e;

    // Whole cycles covering a nanosecond minimum, never less than one.
    function automatic int ns_to_cyc(input int ns, input int period_ns);
        int c;
        c = (ns + period_ns - 1) / period_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sdac_wr_delay.sv
module sdac_wr_delay #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/sdac_wr_csdec.sv
module sdac_wr_csdec #(
    parameter int NUM_TGT = 4,
    parameter int TGT_W   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en_d,
    input  logic [TGT_W-1:0]   idx_d,
    output logic [NUM_TGT-1:0] cs_n_q
);
    logic [NUM_TGT-1:0] sel_d;

    for (genvar g = 0; g < NUM_TGT; g++) begin : g_sel
        assign sel_d[g] = en_d && (idx_d == TGT_W'(g));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_n_q <= '1;
        end else begin
            cs_n_q <= ~sel_d;
        end
    end

    AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~cs_n_q) <= 1); // R3

endmodule

// File: rtl/sdac_wr_ctrl.sv
module sdac_wr_ctrl
    import sdac_wr_pkg::*;
#(
    parameter int DATA_W        = 16,
    parameter int NUM_TGT       = 4,
    parameter int TGT_W         = (NUM_TGT > 1) ? $clog2(NUM_TGT) : 1,
    parameter int SYS_CLK_NS    = 10,
    parameter int SCLK_HALF_NS  = 20,
    parameter int CS_SETUP_NS   = 15,
    parameter int DATA_SETUP_NS = 15,
    parameter int CS_HOLD_NS    = 20,
    parameter int CS_GAP_NS     = 30,
    parameter int LOAD_DELAY_NS = 30,
    parameter int LOAD_WIDTH_NS = 30
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [DATA_W-1:0]  req_data,
    input  logic [TGT_W-1:0]   req_target,
    input  logic               req_load,
    output logic               dac_sclk,
    output logic               dac_sdata,
    output logic [NUM_TGT-1:0] dac_cs_n,
    output logic               dac_load_n
);
    // Data changes as the clock falls, so a half period also covers data setup.
    localparam int HALF_C  = max2(ns_to_cyc(SCLK_HALF_NS, SYS_CLK_NS),
                                  ns_to_cyc(DATA_SETUP_NS, SYS_CLK_NS));
    localparam int SETUP_C = max2(ns_to_cyc(CS_SETUP_NS, SYS_CLK_NS),
                                  ns_to_cyc(DATA_SETUP_NS, SYS_CLK_NS));
    localparam int HOLD_C  = ns_to_cyc(CS_HOLD_NS, SYS_CLK_NS);
    localparam int GAP_C   = ns_to_cyc(CS_GAP_NS, SYS_CLK_NS);
    localparam int LDG_C   = ns_to_cyc(LOAD_DELAY_NS, SYS_CLK_NS);
    localparam int LDW_C   = ns_to_cyc(LOAD_WIDTH_NS, SYS_CLK_NS);
    localparam int MAX_C   = max2(max2(max2(HALF_C, SETUP_C), max2(HOLD_C, GAP_C)),
                                  max2(LDG_C, LDW_C));
    localparam int CNT_W   = $clog2(MAX_C + 1);
    localparam int BIT_W   = (DATA_W > 1) ? $clog2(DATA_W) : 1;

    typedef struct packed {
        sdw_state_e        st;
        logic              sclk;
        logic              sdo;
        logic              ld_n;
        logic              cs_en;
        logic              load_req;
        logic [TGT_W-1:0]  tgt;
        logic [BIT_W-1:0]  bit_left;
        logic [DATA_W-1:0] shift;
    } sdw_regs_t;

    sdw_regs_t        r_d, r_q;
    logic             cnt_load;
    logic [CNT_W-1:0] cnt_val;
    logic             cnt_zero;

    always_comb begin
        r_d      = r_q;
        cnt_load = 1'b0;
        cnt_val  = '0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.st       = ST_SETUP;
                    r_d.cs_en    = 1'b1;
                    r_d.tgt      = req_target;
                    r_d.load_req = req_load;
                    r_d.sdo      = req_data[DATA_W-1];
                    r_d.shift    = req_data << 1;
                    r_d.bit_left = BIT_W'(DATA_W - 1);
                    cnt_load     = 1'b1;
                    cnt_val      = CNT_W'(SETUP_C - 1);
                end
            end
            ST_SETUP, ST_LOW: begin
                if (cnt_zero) begin
                    r_d.st   = ST_HIGH;
                    r_d.sclk = 1'b1;
                    cnt_load = 1'b1;
                    cnt_val  = CNT_W'(HALF_C - 1);
                end
            end
            ST_HIGH: begin
                if (cnt_zero) begin
                    r_d.sclk = 1'b0;
                    cnt_load = 1'b1;
                    if (r_q.bit_left == '0) begin
                        r_d.st  = ST_HOLD;
                        cnt_val = CNT_W'(HOLD_C - 1);
                    end else begin
                        r_d.st       = ST_LOW;
                        r_d.bit_left = r_q.bit_left - 1'b1;
                        r_d.sdo      = r_q.shift[DATA_W-1];
                        r_d.shift    = r_q.shift << 1;
                        cnt_val      = CNT_W'(HALF_C - 1);
                    end
                end
            end
            ST_HOLD: begin
                if (cnt_zero) begin
                    r_d.cs_en = 1'b0;
                    r_d.sdo   = 1'b0;
                    cnt_load  = 1'b1;
                    if (r_q.load_req) begin
                        r_d.st  = ST_LDGAP;
                        cnt_val = CNT_W'(LDG_C - 1);
                    end else begin
                        r_d.st  = ST_RECOV;
                        cnt_val = CNT_W'(GAP_C - 1);
                    end
                end
            end
            ST_LDGAP: begin
                if (cnt_zero) begin
                    r_d.st   = ST_LDPULSE;
                    r_d.ld_n = 1'b0;
                    cnt_load = 1'b1;
                    cnt_val  = CNT_W'(LDW_C - 1);
                end
            end
            ST_LDPULSE: begin
                if (cnt_zero) begin
                    r_d.st   = ST_RECOV;
                    r_d.ld_n = 1'b1;
                    cnt_load = 1'b1;
                    cnt_val  = CNT_W'(GAP_C - 1);
                end
            end
            ST_RECOV: begin
                if (cnt_zero) begin
                    r_d.st = ST_IDLE;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.st    <= ST_IDLE;
            r_q.ld_n  <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    sdac_wr_delay #(.CNT_W(CNT_W)) u_delay (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_val),
        .zero     (cnt_zero)
    );

    sdac_wr_csdec #(.NUM_TGT(NUM_TGT), .TGT_W(TGT_W)) u_csdec (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_d   (r_d.cs_en),
        .idx_d  (r_d.tgt),
        .cs_n_q (dac_cs_n)
    );

    assign req_ready  = (r_q.st == ST_IDLE);
    assign dac_sclk   = r_q.sclk;
    assign dac_sdata  = r_q.sdo;
    assign dac_load_n = r_q.ld_n;

    // Run length of the serial clock high phase, for the width assertion.
    logic [CNT_W:0] hi_run_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_run_q <= '0;
        end else if (dac_sclk) begin
            if (hi_run_q != '1) hi_run_q <= hi_run_q + 1'b1;
        end else begin
            hi_run_q <= '0;
        end
    end

    AST_SCLK_HIGH_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dac_sclk) |-> (hi_run_q >= (CNT_W+1)'(HALF_C))); // R5
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (&dac_cs_n) |-> (!dac_sclk && !dac_sdata)); // R9
    AST_LOAD_OUTSIDE_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        !dac_load_n |-> (&dac_cs_n)); // R10
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        !(&dac_cs_n) |-> !req_ready); // R2
    AST_ACCEPT_SELECTS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && (int'(req_target) < NUM_TGT))
            |=> !dac_cs_n[$past(req_target)]); // R3
    AST_DATA_ON_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!(&dac_cs_n) && !$stable(dac_sdata)) |-> !dac_sclk); // R6

endmodule

// File: tb/sdac_wr_ctrl_bench.sv
module sdac_wr_ctrl_bench;
    localparam int CLK_NS  = 10;
    localparam int NT      = 4;
    localparam int DW      = 16;
    localparam int E_HALF  = (20 + CLK_NS - 1) / CLK_NS;
    localparam int E_PER   = (40 + CLK_NS - 1) / CLK_NS;
    localparam int E_CSSU  = (15 + CLK_NS - 1) / CLK_NS;
    localparam int E_DSU   = (15 + CLK_NS - 1) / CLK_NS;
    localparam int E_HOLD  = (20 + CLK_NS - 1) / CLK_NS;
    localparam int E_GAP   = (30 + CLK_NS - 1) / CLK_NS;
    localparam int E_LDG   = (30 + CLK_NS - 1) / CLK_NS;
    localparam int E_LDW   = (30 + CLK_NS - 1) / CLK_NS;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [DW-1:0] req_data = '0;
    logic [1:0]    req_target = '0;
    logic          req_load = 1'b0;
    logic          dac_sclk, dac_sdata, dac_load_n;
    logic [NT-1:0] dac_cs_n;

    always #(CLK_NS/2) clk = ~clk;

    sdac_wr_ctrl #(.DATA_W(DW), .NUM_TGT(NT), .SYS_CLK_NS(CLK_NS)) u_sdac_wr_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_data(req_data), .req_target(req_target), .req_load(req_load),
        .dac_sclk(dac_sclk), .dac_sdata(dac_sdata), .dac_cs_n(dac_cs_n),
        .dac_load_n(dac_load_n)
    );

    typedef struct packed {
        logic          ld;
        logic [1:0]    tg;
        logic [DW-1:0] d;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   errors = 0;
    int   sent = 0;
    int   frames_seen = 0;
    int   ld_exp = 0;
    int   ld_seen = 0;
    bit   done = 1'b0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Interval monitor and receiver models, sampled on the falling clock edge.
    int            t = 0;
    int            last_rise = -1000, fall_t = -1000, dchg_t = -1000;
    int            cs_fall_t = -1000, cs_rise_t = -1000, ld_fall_t = -1000;
    bit            first_rise = 1'b0, had_frame = 1'b0;
    logic          p_sclk = 1'b0, p_sdo = 1'b0, p_ld = 1'b1;
    logic [NT-1:0] p_cs = '1;
    logic [DW-1:0] rx_w [NT];
    int            rx_n [NT];

    always @(negedge clk) begin
        if (rst_n) begin
            t++;
            if ((&dac_cs_n) && (dac_sclk || dac_sdata))
                chk(1'b0, "R9 idle bus", {dac_sclk, dac_sdata}, 0);
            if ($countones(~dac_cs_n) > 1)
                chk(1'b0, "R3 multiple selects", $countones(~dac_cs_n), 1);
            if (!dac_load_n && !(&dac_cs_n))
                chk(1'b0, "R10 strobe in frame", dac_cs_n, {NT{1'b1}});
            // select falls
            if ((&p_cs) && !(&dac_cs_n)) begin
                if (had_frame) chk(t - cs_rise_t >= E_GAP, "R8 select gap", t - cs_rise_t, E_GAP);
                chk(ld_seen == ld_exp, "R10 strobe count before next frame", ld_seen, ld_exp);
                cs_fall_t  = t;
                first_rise = 1'b1;
            end
            for (int i = 0; i < NT; i++) begin
                if (p_cs[i] && !dac_cs_n[i]) begin
                    rx_n[i] = 0;
                    rx_w[i] = '0;
                end
            end
            if (dac_sdata !== p_sdo) begin
                dchg_t = t;
                if (!(&dac_cs_n)) chk(!dac_sclk, "R6 data change while clock low", dac_sclk, 0);
            end
            if (dac_sclk && !p_sclk) begin
                if (first_rise)
                    chk(t - cs_fall_t >= E_CSSU, "R6 select setup", t - cs_fall_t, E_CSSU);
                else begin
                    chk(t - last_rise >= E_PER, "R5 period", t - last_rise, E_PER);
                    chk(t - fall_t >= E_HALF, "R5 low time", t - fall_t, E_HALF);
                end
                chk(t - dchg_t >= E_DSU, "R6 data setup", t - dchg_t, E_DSU);
                first_rise = 1'b0;
                last_rise  = t;
                for (int i = 0; i < NT; i++) begin
                    if (!dac_cs_n[i]) begin
                        rx_w[i] = {rx_w[i][DW-2:0], dac_sdata};
                        rx_n[i]++;
                    end
                end
            end
            if (!dac_sclk && p_sclk) begin
                chk(t - last_rise >= E_HALF, "R5 high time", t - last_rise, E_HALF);
                fall_t = t;
            end
            for (int i = 0; i < NT; i++) begin
                if (!p_cs[i] && dac_cs_n[i]) begin
                    exp_t e;
                    chk(t - last_rise >= E_HOLD, "R7 select hold", t - last_rise, E_HOLD);
                    frames_seen++;
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R2 frame without request", frames_seen, sent);
                    end else begin
                        e = exp_q.pop_front();
                        ld_exp += int'(e.ld);
                        chk(i == int'(e.tg), "R3 addressed target", i, e.tg);
                        chk(rx_n[i] == DW, "R4 bit count", rx_n[i], DW);
                        chk(rx_w[i] == e.d, "R4 received word", rx_w[i], e.d);
                    end
                    cs_rise_t = t;
                    had_frame = 1'b1;
                end
            end
            if (!dac_load_n && p_ld) begin
                ld_seen++;
                chk(t - cs_rise_t >= E_LDG, "R10 strobe delay", t - cs_rise_t, E_LDG);
                ld_fall_t = t;
            end
            if (dac_load_n && !p_ld)
                chk(t - ld_fall_t >= E_LDW, "R10 strobe width", t - ld_fall_t, E_LDW);
            p_sclk = dac_sclk;
            p_sdo  = dac_sdata;
            p_cs   = dac_cs_n;
            p_ld   = dac_load_n;
        end
    end

    task automatic send(input logic [DW-1:0] d, input int tg, input bit ld);
        @(negedge clk);
        req_valid  = 1'b1;
        req_data   = d;
        req_target = tg[1:0];
        req_load   = ld;
        while (!req_ready) @(negedge clk);
        exp_q.push_back({ld, tg[1:0], d});
        sent++;
        @(negedge clk);
        req_valid = 1'b0;
        chk(!req_ready, "R2 busy after accept", req_ready, 0);
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (!req_ready || exp_q.size() != 0) @(negedge clk);
        repeat (E_LDG + E_LDW + 2) @(negedge clk);
    endtask

    initial begin
        int seed;
        seed = $urandom(32'd8151);
        for (int i = 0; i < NT; i++) begin
            rx_w[i] = '0;
            rx_n[i] = 0;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(dac_cs_n == '1, "R1 selects high", dac_cs_n, {NT{1'b1}});
        chk(!dac_sclk, "R1 clock low", dac_sclk, 0);
        chk(!dac_sdata, "R1 data low", dac_sdata, 0);
        chk(dac_load_n, "R1 strobe high", dac_load_n, 1);
        chk(req_ready, "R1 ready", req_ready, 1);

        // directed corners: bit ends, all ones, all zeros, alternating
        send(16'h8001, 0, 1'b1);
        wait_idle();
        send(16'hFFFF, 3, 1'b0);
        wait_idle();
        send(16'h0000, 2, 1'b1);
        wait_idle();
        send(16'hA5A5, 1, 1'b1);
        // R2 back-to-back: request waits through strobe and recovery
        send(16'h5A5A, 1, 1'b0);
        send(16'h7FFE, 2, 1'b1);
        wait_idle();
        // R10 no strobe when not requested
        chk(ld_seen == ld_exp, "R10 strobe total", ld_seen, ld_exp);

        for (int k = 0; k < 24; k++) begin
            send(DW'($urandom), int'($urandom % NT), bit'($urandom % 2));
            if ($urandom % 3 == 0) wait_idle();
        end
        wait_idle();
        chk(frames_seen == sent, "R4 frame total", frames_seen, sent);
        chk(ld_seen == ld_exp, "R10 strobe total end", ld_seen, ld_exp);
        chk(dac_cs_n == '1, "R9 selects released", dac_cs_n, {NT{1'b1}});
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            chk(1'b0, "watchdog R2", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule